// File: doc/BRIEF.md
# Character LCD Bus Cycle Engine

This block runs one bus transaction at a time on an 8-bit parallel character-display bus made of a register-select line, a read/write line, an enable strobe and a data bus that can be driven in either direction. The requester supplies the register-select level, the direction and, for a write, the byte. The engine places the select and direction lines first. It then raises the enable strobe for the required time and either drives the write byte or captures the byte returned by the display. After the enable strobe it keeps the bus quiet for the execution time of the command it has just issued, and then reports completion.

Every phase length is a whole number of clock cycles. Each length is derived by ceiling division from nanosecond minimums and from the clock frequency parameter, so no minimum is ever shortened. The engine classifies each transaction to choose the execution wait. To do this it tracks whether data accesses currently address the glyph memory or the display memory, which it learns by watching the address-set commands that pass through it. The data bus has a separate output, output enable and input, and the tri-state buffer sits outside the block.

Top module: `lcd_cycle_engine`

## Requirements
- R1: After a request is accepted, the select and direction lines take the request values at the accepting edge, and the enable strobe rises after exactly ceil(140 ns) clock cycles of setup.
- R2: The enable strobe stays high for max(ceil(450 ns), ceil(320 ns)+2) cycles.
- R3: The select and direction lines hold their values unchanged from the accepting edge until busy drops, which covers at least ceil(10 ns) cycles after the enable strobe falls.
- R4: On a read, the data output enable stays low for the whole transaction. The read byte is captured at the clock edge that ends enable-high cycle number ceil(320 ns)+1, while the strobe is still high, and it is held on rdData until the next read.
- R5: On a write, the data output enable is high and the request byte is on the data output from the accepting edge until the hold of ceil(10 ns) cycles after the enable strobe falls.
- R6: After the hold, the engine waits at least ceil(1000 ns) − high − hold cycles, so that successive enable rising edges are at least 1000 ns apart.
- R7: The post-hold wait is the larger of the R6 gap and the execution wait of the command class. A write with select low whose byte has bits 7..2 zero and bits 1..0 non-zero gets the clear/home wait. A select-high access while in glyph mode gets the glyph wait. Any other select-high access, and any other select-low write, gets the short wait. A select-low read (status) gets no extra wait.
- R8: A select-low write with bit 7 set switches the engine to display-memory mode. A select-low write with bits 7..6 equal to 01 switches it to glyph mode. Reset selects display-memory mode.
- R9: A request is accepted only while busy is low. Busy is high from the cycle after acceptance until the wait ends, and requests presented while busy are ignored.
- R10: done is a one-cycle pulse in the first cycle with busy low after a transaction.
- R11: Reset, asynchronous and active low, forces enable low, output enable low, busy and done low, rdData to 0, the select line to 0 and the direction line to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqRs | input | 1 | Register-select level for the request |
| reqRw | input | 1 | 1 = read, 0 = write |
| reqData | input | 8 | Byte to write |
| busy | output | 1 | Transaction or execution wait in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Last byte read from the display |
| lcdRs | output | 1 | Register-select line |
| lcdRw | output | 1 | Read/write line |
| lcdE | output | 1 | Enable strobe |
| lcdDataOut | output | 8 | Data bus output value |
| lcdDataOe | output | 1 | Data bus output enable |
| lcdDataIn | input | 8 | Data bus input value |

## Verification
The in-line properties watch, on every cycle, that the select and direction lines stay steady while busy, that the bus is never driven during a read, that the write byte stays steady while driven, that the capture point lies inside the enable pulse, and that done stays a single pulse. The phase lengths in cycles, the choice of execution wait for each command class, the glyph/display mode tracking across a sequence of commands, the timing of the read capture against a slow data source, and reset in the middle of a pulse can only be shown by the bench's scenarios.

// File: rtl/lcd_cyc_pkg.sv
package lcd_cyc_pkg;

  typedef enum logic [1:0] {
    WAIT_NONE,
    WAIT_SHORT,
    WAIT_GLYPH,
    WAIT_CLEAR
  } waitClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture request fields
    logic sample;  // capture read byte
    logic drive;   // bus phase active (setup, high, hold)
  } cycStrobe_t;

  // round up so that no minimum is shortened
  function automatic int nsToCycles(longint ns, longint clkHz);
    return int'((ns * clkHz + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/lcd_cyc_ctrl.sv
module lcd_cyc_ctrl
  import lcd_cyc_pkg::*;
#(
  parameter longint CLK_HZ    = 125_000_000,
  parameter longint SETUP_NS  = 140,
  parameter longint PULSE_NS  = 450,
  parameter longint PERIOD_NS = 1000,
  parameter longint HOLD_NS   = 10,
  parameter longint RDDLY_NS  = 320,
  parameter longint SHORT_NS  = 40_000,
  parameter longint GLYPH_NS  = 120_000,
  parameter longint CLEAR_NS  = 1_640_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  waitClass_e waitSel,
  output cycStrobe_t stb,
  output logic       lcdE,
  output logic       busy,
  output logic       done
);

  localparam int SETUP_RAW = nsToCycles(SETUP_NS, CLK_HZ);
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int DLY_CYC   = nsToCycles(RDDLY_NS, CLK_HZ);
  localparam int PULSE_RAW = nsToCycles(PULSE_NS, CLK_HZ);
  localparam int HIGH_CYC  = (PULSE_RAW > DLY_CYC + 2) ? PULSE_RAW : DLY_CYC + 2;
  localparam int HOLD_RAW  = nsToCycles(HOLD_NS, CLK_HZ);
  localparam int HOLD_CYC  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int GAP_RAW   = nsToCycles(PERIOD_NS, CLK_HZ) - HIGH_CYC - HOLD_CYC;
  localparam int GAP_CYC   = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int SHORT_RAW = nsToCycles(SHORT_NS, CLK_HZ);
  localparam int GLYPH_RAW = nsToCycles(GLYPH_NS, CLK_HZ);
  localparam int CLEAR_RAW = nsToCycles(CLEAR_NS, CLK_HZ);
  localparam int LIM_NONE  = GAP_CYC;
  localparam int LIM_SHORT = (SHORT_RAW > GAP_CYC) ? SHORT_RAW : GAP_CYC;
  localparam int LIM_GLYPH = (GLYPH_RAW > GAP_CYC) ? GLYPH_RAW : GAP_CYC;
  localparam int LIM_CLEAR = (CLEAR_RAW > GAP_CYC) ? CLEAR_RAW : GAP_CYC;
  localparam int MAX_A     = (LIM_SHORT > LIM_GLYPH) ? LIM_SHORT : LIM_GLYPH;
  localparam int MAX_B     = (LIM_CLEAR > HIGH_CYC) ? LIM_CLEAR : HIGH_CYC;
  localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL   = (MAX_C > SETUP_CYC) ? MAX_C : SETUP_CYC;
  localparam int CNT_W     = $clog2(MAX_ALL + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIGH, S_HOLD, S_WAIT} phase_e;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] waitLast;

  always_comb begin
    unique case (waitSel)
      WAIT_NONE:  waitLast = CNT_W'(LIM_NONE - 1);
      WAIT_SHORT: waitLast = CNT_W'(LIM_SHORT - 1);
      WAIT_GLYPH: waitLast = CNT_W'(LIM_GLYPH - 1);
      default:    waitLast = CNT_W'(LIM_CLEAR - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt + 1'b1;
      unique case (phase)
        S_IDLE: begin
          cnt <= '0;
          if (reqValid) phase <= S_SETUP;
        end
        S_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          phase <= S_HIGH;
          cnt   <= '0;
        end
        S_HIGH: if (cnt == CNT_W'(HIGH_CYC - 1)) begin
          phase <= S_HOLD;
          cnt   <= '0;
        end
        S_HOLD: if (cnt == CNT_W'(HOLD_CYC - 1)) begin
          phase <= S_WAIT;
          cnt   <= '0;
        end
        default: if (cnt == waitLast) begin
          phase <= S_IDLE;
          cnt   <= '0;
          done  <= 1'b1;
        end
      endcase
    end
  end

  assign lcdE       = (phase == S_HIGH);
  assign busy       = (phase != S_IDLE);
  assign stb.load   = (phase == S_IDLE) && reqValid;
  assign stb.sample = (phase == S_HIGH) && (cnt == CNT_W'(DLY_CYC));
  assign stb.drive  = (phase == S_SETUP) || (phase == S_HIGH) || (phase == S_HOLD);

  // R1: enable only rises after the full setup count
  p_setup_before_e_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lcdE) |-> ($past(phase) == S_SETUP && $past(cnt) == CNT_W'(SETUP_CYC - 1)));
  // R4: capture edge still inside the pulse
  p_sample_in_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |=> lcdE);
  // R9: an idle request is taken
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);
  // R10: done is a lone pulse outside busy
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/lcd_cyc_path.sv
module lcd_cyc_path
  import lcd_cyc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cycStrobe_t stb,
  input  logic       busy,
  input  logic       reqRs,
  input  logic       reqRw,
  input  logic [7:0] reqData,
  input  logic [7:0] lcdDataIn,
  output waitClass_e waitSel,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic [7:0] lcdDataOut,
  output logic       lcdDataOe,
  output logic [7:0] rdData
);

  logic       glyphMode;
  waitClass_e nextClass;

  always_comb begin
    if (reqRs)
      nextClass = glyphMode ? WAIT_GLYPH : WAIT_SHORT;
    else if (reqRw)
      nextClass = WAIT_NONE;
    else if (reqData[7:2] == 6'd0 && reqData[1:0] != 2'd0)
      nextClass = WAIT_CLEAR;
    else
      nextClass = WAIT_SHORT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lcdRs      <= 1'b0;
      lcdRw      <= 1'b1;
      lcdDataOut <= '0;
      rdData     <= '0;
      glyphMode  <= 1'b0;
      waitSel    <= WAIT_NONE;
    end else begin
      if (stb.load) begin
        lcdRs      <= reqRs;
        lcdRw      <= reqRw;
        lcdDataOut <= reqData;
        waitSel    <= nextClass;
        if (!reqRs && !reqRw) begin
          if (reqData[7])                 glyphMode <= 1'b0;
          else if (reqData[7:6] == 2'b01) glyphMode <= 1'b1;
        end
      end
      if (stb.sample && lcdRw) rdData <= lcdDataIn;
    end
  end

  assign lcdDataOe = stb.drive && !lcdRw;

  // R3: select and direction steady through the transaction
  p_rsrw_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(lcdRs) && $stable(lcdRw)));
  // R4: never drive during a read
  p_read_undriven_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lcdRw) |-> !lcdDataOe);
  // R5: write byte steady while driven
  p_wdata_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lcdDataOe && $past(busy)) |-> $stable(lcdDataOut));

endmodule

// File: rtl/lcd_cycle_engine.sv
module lcd_cycle_engine
  import lcd_cyc_pkg::*;
#(
  parameter longint CLK_HZ   = 125_000_000,
  parameter longint SHORT_NS = 40_000,
  parameter longint GLYPH_NS = 120_000,
  parameter longint CLEAR_NS = 1_640_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqRs,
  input  logic       reqRw,
  input  logic [7:0] reqData,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdData,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdE,
  output logic [7:0] lcdDataOut,
  output logic       lcdDataOe,
  input  logic [7:0] lcdDataIn
);

  cycStrobe_t stb;
  waitClass_e waitSel;

  lcd_cyc_ctrl #(
    .CLK_HZ(CLK_HZ), .SHORT_NS(SHORT_NS), .GLYPH_NS(GLYPH_NS), .CLEAR_NS(CLEAR_NS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .waitSel(waitSel),
    .stb(stb), .lcdE(lcdE), .busy(busy), .done(done)
  );

  lcd_cyc_path uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .reqRs(reqRs), .reqRw(reqRw), .reqData(reqData), .lcdDataIn(lcdDataIn),
    .waitSel(waitSel), .lcdRs(lcdRs), .lcdRw(lcdRw),
    .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe), .rdData(rdData)
  );

endmodule

// File: tb/sim_lcd_cycle_engine.sv
module sim_lcd_cycle_engine;

  localparam longint CLK_HZ   = 125_000_000;
  localparam longint SHORT_NS = 400;
  localparam longint GLYPH_NS = 1_200;
  localparam longint CLEAR_NS = 16_400;

  function automatic int cyc(longint ns);
    return int'((ns * CLK_HZ + 999_999_999) / 1_000_000_000);
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SETUP = cyc(140);
  localparam int E_HIGH  = imax(cyc(450), cyc(320) + 2);
  localparam int E_HOLD  = imax(1, cyc(10));
  localparam int E_GAP   = imax(1, cyc(1000) - E_HIGH - E_HOLD);
  localparam int E_CAP   = cyc(320) + 1;

  logic clk = 0, rstN = 0, reqValid = 0, reqRs = 0, reqRw = 0;
  logic [7:0] reqData = 0, lcdDataIn = 0, rdModel = 0;
  logic busy, done, lcdRs, lcdRw, lcdE, lcdDataOe;
  logic [7:0] rdData, lcdDataOut;
  int vectors = 0, miscompares = 0, eCnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lcd_cycle_engine #(.CLK_HZ(CLK_HZ), .SHORT_NS(SHORT_NS), .GLYPH_NS(GLYPH_NS),
                     .CLEAR_NS(CLEAR_NS)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRs(reqRs), .reqRw(reqRw),
    .reqData(reqData), .busy(busy), .done(done), .rdData(rdData), .lcdRs(lcdRs),
    .lcdRw(lcdRw), .lcdE(lcdE), .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe),
    .lcdDataIn(lcdDataIn));

  // slow display model: byte valid only from the 320 ns point of the pulse
  always @(negedge clk) begin
    if (!lcdE) eCnt = 0; else eCnt = eCnt + 1;
    lcdDataIn = (eCnt >= E_CAP) ? rdModel : (rdModel ^ 8'h5A);
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int limOf(int cls);
    case (cls)
      0: return E_GAP;
      1: return imax(E_GAP, cyc(SHORT_NS));
      2: return imax(E_GAP, cyc(GLYPH_NS));
      default: return imax(E_GAP, cyc(CLEAR_NS));
    endcase
  endfunction

  task automatic runReq(logic rs, logic rw, logic [7:0] wd, logic [7:0] rv, int cls, bit spam);
    int n = 0, eh = 0, su = 0, oe = 0, rsBad = 0, dBad = 0, dn = 0;
    @(negedge clk);
    reqRs = rs; reqRw = rw; reqData = wd; reqValid = 1; rdModel = rv;
    @(negedge clk);
    if (spam) begin reqRs = ~rs; reqRw = ~rw; reqData = ~wd; end
    else reqValid = 0;
    while (busy) begin
      if (spam && n == 20) reqValid = 0;
      n++;
      if (lcdE) eh++; else if (eh == 0) su++;
      if (lcdDataOe) oe++;
      if (lcdRs != rs || lcdRw != rw) rsBad++;
      if (lcdDataOe && lcdDataOut != wd) dBad++;
      if (done) dn++;
      @(negedge clk);
    end
    reqValid = 0;
    chk("R1 setup cycles", su, E_SETUP);
    chk("R2 enable high cycles", eh, E_HIGH);
    chk("R3/R9 rs rw steady", rsBad, 0);
    chk("R4/R5 drive cycles", oe, rw ? 0 : E_SETUP + E_HIGH + E_HOLD);
    chk("R5 write byte", dBad, 0);
    chk("R6/R7 busy cycles", n, E_SETUP + E_HIGH + E_HOLD + limOf(cls));
    chk("R10 done pulse", {31'd0, done} + dn, 1);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 0);
    chk("R9 no extra accept", {31'd0, busy}, 0);
    if (rw) chk("R4 read byte", int'(rdData), int'(rv));
  endtask

  typedef struct packed {
    logic rs; logic rw; logic [7:0] wd; logic [7:0] rv; logic [1:0] cls;
  } vec_t;
  // cls: 0 none, 1 short, 2 glyph, 3 clear/home
  localparam vec_t VEC[12] = '{
    '{1'b0, 1'b0, 8'h38, 8'h00, 2'd1},  // function set
    '{1'b0, 1'b0, 8'h01, 8'h00, 2'd3},  // clear
    '{1'b0, 1'b0, 8'h02, 8'h00, 2'd3},  // home
    '{1'b0, 1'b0, 8'h03, 8'h00, 2'd3},  // home, low bit ignored
    '{1'b0, 1'b1, 8'h00, 8'h25, 2'd0},  // status read
    '{1'b0, 1'b0, 8'h58, 8'h00, 2'd1},  // glyph address, R8
    '{1'b1, 1'b0, 8'h1F, 8'h00, 2'd2},  // glyph write, R7
    '{1'b1, 1'b1, 8'h00, 8'hA5, 2'd2},  // glyph read
    '{1'b0, 1'b0, 8'h80, 8'h00, 2'd1},  // display address, R8
    '{1'b1, 1'b0, 8'h41, 8'h00, 2'd1},  // display write
    '{1'b1, 1'b1, 8'h00, 8'h3C, 2'd1},  // display read
    '{1'b0, 1'b0, 8'h00, 8'h00, 2'd1}   // zero byte: not clear
  };

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      miscompares++; vectors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 enable", {31'd0, lcdE}, 0);
    chk("R11 oe", {31'd0, lcdDataOe}, 0);
    chk("R11 busy", {31'd0, busy}, 0);
    chk("R11 done", {31'd0, done}, 0);
    chk("R11 rdData", int'(rdData), 0);
    chk("R11 rw", {31'd0, lcdRw}, 1);
    @(negedge clk); rstN = 1;

    for (int i = 0; i < 12; i++)
      runReq(VEC[i].rs, VEC[i].rw, VEC[i].wd, VEC[i].rv, int'(VEC[i].cls), 1'b0);

    // R9: requests held during busy are ignored
    runReq(1'b1, 1'b0, 8'h6E, 8'h00, 1, 1'b1);
    // R4: write leaves the read byte untouched
    chk("R4 rdData held", int'(rdData), 8'h3C);

    // R8/R11: reset mid-pulse drops the bus and returns to display mode
    runReq(1'b0, 1'b0, 8'h48, 8'h00, 1, 1'b0);
    @(negedge clk);
    reqRs = 1; reqRw = 0; reqData = 8'h11; reqValid = 1;
    @(negedge clk); reqValid = 0;
    repeat (E_SETUP + 10) @(negedge clk);
    chk("R2 pulse active", {31'd0, lcdE}, 1);
    rstN = 0; #1;
    chk("R11 enable async", {31'd0, lcdE}, 0);
    chk("R11 busy async", {31'd0, busy}, 0);
    chk("R11 oe async", {31'd0, lcdDataOe}, 0);
    @(negedge clk); rstN = 1;
    runReq(1'b1, 1'b0, 8'h22, 8'h00, 1, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule